// File: doc/BRIEF.md
# Two-Digit BCD to Binary Converter

This block turns a two-digit packed decimal value into plain binary. The tens digit is limited to the range that its input width allows (0 to 3 for the default two bits), and the units digit is a standard 4-bit decimal digit. The units bit of weight one goes straight to binary bit 0. Each remaining input line adds a fixed weight to the sum: the three upper units bits add 2, 4 and 8, and each tens bit adds ten times its own binary weight (10 and 20 by default). The default result range is 0 to 39 on a 6-bit output.

The block also has a complement output for the units digit alone. A select input picks the nine's complement (9 minus the digit) or the ten's complement ((10 minus the digit) mod 10). This helps with decimal subtraction. An active-low enable gates both outputs. When the enable is inactive, or the units digit is not a legal decimal code, every output line is driven high. The block is purely combinational and has no storage.

Top module: `bcd2bin_conv`

## Requirements
- R1: With en_n low and units_i at most 9, bin_o equals 10 × tens_i + units_i.
- R2: With en_n low and units_i at most 9, bit 0 of bin_o equals bit 0 of units_i.
- R3: With en_n low, units_i at most 9 and cmp_ten low, cmp_o equals 9 − units_i.
- R4: With en_n low, units_i at most 9 and cmp_ten high, cmp_o equals (10 − units_i) mod 10, so a units digit of 0 gives 0.
- R5: With en_n high, every bit of bin_o and cmp_o is 1, whatever the other inputs are.
- R6: With en_n low and units_i in the range 10 to 15, every bit of bin_o and cmp_o is 1.
- R7: cmp_o depends only on units_i, cmp_ten and en_n. It is the same for every tens_i value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| en_n | input | 1 | Active-low enable. When high, all outputs are forced to ones. |
| cmp_ten | input | 1 | Complement kind: 0 selects nine's complement, 1 selects ten's complement. |
| tens_i | input | TENS_W (2) | Tens digit in binary. |
| units_i | input | 4 | Units digit in BCD. Codes 10 to 15 are illegal. |
| bin_o | output | BIN_W (6) | Binary value of the two-digit input. |
| cmp_o | output | 4 | Complement of the units digit, in BCD. |

## Verification
No register lies between any input and either output, so bin_o and cmp_o are due in the same cycle as the stimulus that causes them. The bench changes the inputs just after a rising clock edge and compares both outputs at the next falling edge, half a period later. By then the combinational paths have settled and no new stimulus has been applied. The sweep covers every combination of tens digit, units code (legal and illegal), complement kind and enable level. Expected values come from plain decimal arithmetic.

// File: rtl/bcd2bin_pkg.sv
// Package: shared constants, the complement-kind encoding and the width
// rule for the BCD to binary converter.
// Assumes a units digit is always four bits wide.
package bcd2bin_pkg;

    localparam int DIGIT_W   = 4;
    localparam int DIGIT_MAX = 9;

    // Which complement the complement output carries.
    typedef enum logic {
        CMP_NINE = 1'b0,
        CMP_TEN  = 1'b1
    } cmp_kind_e;

    // Gives the bits needed for the largest two-digit value that a tens
    // field of tens_w bits can express.
    function automatic int bin_width(input int tens_w);
        int top_val;
        top_val = 10 * ((1 << tens_w) - 1) + DIGIT_MAX;
        return $clog2(top_val + 1);
    endfunction

endpackage

// File: rtl/bcd2bin_weight_sum.sv
// Module: adds the fixed weights of the active input lines to form the
// binary value. Units bit 0 bypasses the adder tree as binary bit 0.
// Assumes the caller handles illegal units codes. This module only sums.
module bcd2bin_weight_sum #(
    parameter int TENS_W = 2,
    parameter int BIN_W  = 6
) (
    input  logic [TENS_W-1:0]                 tens_i,
    input  logic [bcd2bin_pkg::DIGIT_W-1:0]   units_i,
    output logic [BIN_W-1:0]                  sum_o
);
    import bcd2bin_pkg::*;

    localparam int UNIT_LINES = DIGIT_W - 1;
    localparam int LINES      = UNIT_LINES + TENS_W;

    logic [BIN_W-1:0] term [LINES];

    // Units lines: weights 2, 4, 8.
    for (genvar k = 0; k < UNIT_LINES; k++) begin : g_unit_line
        assign term[k] = units_i[k+1] ? BIN_W'(2 << k) : '0;
    end

    // Tens lines: weights 10, 20, 40, ...
    for (genvar j = 0; j < TENS_W; j++) begin : g_tens_line
        assign term[UNIT_LINES+j] = tens_i[j] ? BIN_W'(10 << j) : '0;
    end

    // Accumulates every line weight on top of the bypassed LSB.
    always_comb begin
        sum_o = BIN_W'(units_i[0]);
        for (int n = 0; n < LINES; n++) begin
            sum_o = sum_o + term[n];
        end
    end

endmodule

// File: rtl/bcd2bin_complement.sv
// Module: forms the nine's or ten's complement of one BCD digit.
// Assumes the digit is legal (0..9). Illegal codes give don't-care values
// that the top level masks.
module bcd2bin_complement (
    input  logic [bcd2bin_pkg::DIGIT_W-1:0] digit_i,
    input  bcd2bin_pkg::cmp_kind_e          kind_i,
    output logic [bcd2bin_pkg::DIGIT_W-1:0] comp_o
);
    import bcd2bin_pkg::*;

    logic [DIGIT_W-1:0] nine_c;
    logic [DIGIT_W-1:0] ten_c;

    // Computes both complements, then picks the requested one.
    always_comb begin
        nine_c = DIGIT_W'(DIGIT_MAX) - digit_i;
        ten_c  = (digit_i == '0) ? '0 : DIGIT_W'(DIGIT_MAX + 1) - digit_i;
        comp_o = (kind_i == CMP_TEN) ? ten_c : nine_c;
    end

endmodule

// File: rtl/bcd2bin_validate.sv
// Module: flags whether a units code is a legal decimal digit.
// Assumes a four-bit digit. Codes above nine are illegal.
module bcd2bin_validate (
    input  logic [bcd2bin_pkg::DIGIT_W-1:0] digit_i,
    output logic                            legal_o
);
    import bcd2bin_pkg::*;

    // Range compare against the largest decimal digit.
    always_comb begin
        legal_o = (digit_i <= DIGIT_W'(DIGIT_MAX));
    end

endmodule

// File: rtl/bcd2bin_conv.sv
// Module: top of the two-digit BCD to binary converter. It joins the weighted
// adder, the units complement and the legality check, and forces all
// outputs high when disabled or when the units code is illegal.
// Assumes static inputs between evaluations. The block is purely combinational.
module bcd2bin_conv #(
    parameter  int TENS_W = 2,
    localparam int BIN_W  = bcd2bin_pkg::bin_width(TENS_W)
) (
    input  logic                              en_n,
    input  logic                              cmp_ten,
    input  logic [TENS_W-1:0]                 tens_i,
    input  logic [bcd2bin_pkg::DIGIT_W-1:0]   units_i,
    output logic [BIN_W-1:0]                  bin_o,
    output logic [bcd2bin_pkg::DIGIT_W-1:0]   cmp_o
);
    import bcd2bin_pkg::*;

    logic [BIN_W-1:0]   sum_w;
    logic [DIGIT_W-1:0] comp_w;
    logic               legal_w;
    logic               blank_w;
    cmp_kind_e          kind_w;

    assign kind_w = cmp_kind_e'(cmp_ten);

    bcd2bin_weight_sum #(
        .TENS_W (TENS_W),
        .BIN_W  (BIN_W)
    ) u_sum (
        .tens_i  (tens_i),
        .units_i (units_i),
        .sum_o   (sum_w)
    );

    bcd2bin_complement u_comp (
        .digit_i (units_i),
        .kind_i  (kind_w),
        .comp_o  (comp_w)
    );

    bcd2bin_validate u_valid (
        .digit_i (units_i),
        .legal_o (legal_w)
    );

    // Output gating: blank (all ones) when disabled or the digit is illegal.
    always_comb begin
        blank_w = en_n | ~legal_w;
        bin_o   = blank_w ? '1 : sum_w;
        cmp_o   = blank_w ? '1 : comp_w;
    end

    // Checks the output relations on every change of the settled signals.
    always_comb begin
        if (en_n) begin
            assert_disabled_high_R5: assert (&bin_o && &cmp_o)
                else $error("disabled outputs not all high");
        end
        if (!en_n && units_i > DIGIT_W'(DIGIT_MAX)) begin
            assert_illegal_high_R6: assert (&bin_o && &cmp_o)
                else $error("illegal digit outputs not all high");
        end
        if (!en_n && units_i <= DIGIT_W'(DIGIT_MAX)) begin
            assert_lsb_pass_R2: assert (bin_o[0] == units_i[0])
                else $error("binary LSB does not follow units LSB");
            assert_units_part_R1: assert (bin_o <= BIN_W'(10 * ((1 << TENS_W) - 1) + DIGIT_MAX))
                else $error("binary result out of range");
            if (!cmp_ten) begin
                assert_nine_pair_R3: assert (cmp_o + units_i == DIGIT_W'(DIGIT_MAX))
                    else $error("nine's complement pair does not sum to nine");
            end else begin
                assert_ten_pair_R4: assert (cmp_o <= DIGIT_W'(DIGIT_MAX) &&
                    ((units_i == '0) ? (cmp_o == '0) : (cmp_o + units_i == DIGIT_W'(DIGIT_MAX + 1))))
                    else $error("ten's complement pair wrong");
            end
        end
    end

endmodule

// File: tb/bcd2bin_conv_test.sv
// Bench: drives every tens, units, complement kind and enable combination and
// compares against decimal arithmetic.
module bcd2bin_conv_test;

    localparam int CLK_PERIOD = 10;
    localparam int TENS_W     = 2;
    localparam int BIN_W      = 6;
    localparam int WATCHDOG   = 200000;

    logic             clk = 1'b0;
    logic             en_n = 1'b1;
    logic             cmp_ten = 1'b0;
    logic [TENS_W-1:0] tens_i = '0;
    logic [3:0]       units_i = '0;
    logic [BIN_W-1:0] bin_o;
    logic [3:0]       cmp_o;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;
    int  cmp_ref [16][2];

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd2bin_conv #(.TENS_W(TENS_W)) uut (
        .en_n    (en_n),
        .cmp_ten (cmp_ten),
        .tens_i  (tens_i),
        .units_i (units_i),
        .bin_o   (bin_o),
        .cmp_o   (cmp_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d (en_n=%0b kind=%0b tens=%0d units=%0d)",
                     req, act, exp, en_n, cmp_ten, tens_i, units_i);
        end
    endtask

    initial begin
        // Reset-like idle state: disabled, all ones expected (R5).
        @(negedge clk);
        check("R5 idle bin", int'(bin_o), 63);
        check("R5 idle cmp", int'(cmp_o), 15);

        for (int e = 1; e >= 0; e--) begin
            for (int k = 0; k < 2; k++) begin
                for (int t = 0; t < (1 << TENS_W); t++) begin
                    for (int u = 0; u < 16; u++) begin
                        @(posedge clk);
                        en_n    = e[0];
                        cmp_ten = k[0];
                        tens_i  = t[TENS_W-1:0];
                        units_i = u[3:0];
                        @(negedge clk);
                        if (e == 1) begin
                            check("R5 disabled bin", int'(bin_o), 63);
                            check("R5 disabled cmp", int'(cmp_o), 15);
                        end else if (u > 9) begin
                            check("R6 illegal bin", int'(bin_o), 63);
                            check("R6 illegal cmp", int'(cmp_o), 15);
                        end else begin
                            check("R1 binary value", int'(bin_o), 10 * t + u);
                            check("R2 lsb pass", int'(bin_o[0]), u % 2);
                            if (k == 0)
                                check("R3 nine's complement", int'(cmp_o), 9 - u);
                            else
                                check("R4 ten's complement", int'(cmp_o), (10 - u) % 10);
                            // R7: complement must match the value seen for tens 0.
                            if (t == 0)
                                cmp_ref[u][k] = int'(cmp_o);
                            else
                                check("R7 tens independence", int'(cmp_o), cmp_ref[u][k]);
                        end
                    end
                end
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule